// File: doc/BRIEF.md
# Cartridge ROM/RAM bank controller

This block sits on the CPU write path of an 8-bit handheld cartridge and turns writes into the lower 32 KB ROM window into bank selections. It produces three outputs. The first is a 7-bit bank number for the switchable 16 KB ROM window. The second is a 2-bit bank number for the external RAM. The third is a flag that enables that RAM. The block decodes no reads and holds no memory arrays. Downstream address logic combines its outputs with the CPU address.

Address bits [15:13] pick one of four write targets. The first target gates the RAM. The second loads the low five ROM bank bits, and a zero there is replaced with one. The third is a 2-bit field. A mode flag, set through the fourth target, sends that field either to ROM bank bits [6:5] or to the RAM bank. Every stored ROM bank number is masked to the ROM size, which is given in banks on a static input, so the selected window never runs past the end of the ROM.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the RAM enable is low and the mode flag is 0 (ROM-upper routing). This assumes the ROM size is at least 2 banks.
- R2: A write with address bit 15 set changes no output. A cycle with the write strobe low also changes no output.
- R3: A write of 0x0A to 0x0000–0x1FFF sets the RAM enable, and a write of 0x00 there clears it. Any other value leaves the enable as it was.
- R4: A write to 0x2000–0x3FFF replaces ROM bank bits [4:0] with data bits [4:0], and a value of 0 in those bits is loaded as 1. ROM bank bits [6:5] keep their value.
- R5: In mode 0, a write to 0x4000–0x5FFF replaces ROM bank bits [6:5] with data bits [1:0] and keeps bits [4:0]. The RAM bank does not change.
- R6: In mode 1, a write to 0x4000–0x5FFF loads data bits [1:0] into the RAM bank. The ROM bank does not change.
- R7: A write to 0x6000–0x7FFF sets the mode from data bit 0. Mode 1 clears ROM bank bits [6:5]. Mode 0 sets the RAM bank to 0.
- R8: Every ROM bank number the block stores equals the composed value ANDed with (rom_size − 1). rom_size is a power of two.
- R9: The outputs change only at the rising clock edge on which the write strobe is high. The new value is visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_size | input | 8 | ROM size in 16 KB banks, power of two, held stable |
| rom_bank | output | 7 | Bank number for the switchable ROM window |
| ram_bank | output | 2 | External RAM bank number |
| ram_en | output | 1 | External RAM enable |

## Verification
The assertions check these rules on every cycle. The stored ROM bank never has a bit set above the size mask. The outputs hold still unless a write lands below 0x8000. The enable only moves on the two accepted code values. A mode-0 write to the mode target leaves the RAM bank at zero. A mode-1 write to the shared field lands in the RAM bank. Some rules need a chain of writes to show up, and only the bench scenarios can show them. These are: the upper ROM bits surviving a low-bank write, the zero-to-one substitution combined with non-zero upper bits, the clearing of the upper bits when mode 1 is entered, and wrapping under small ROM sizes.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [2:0] {
    RG_GATE  = 3'd0,
    RG_LOW   = 3'd1,
    RG_SHARE = 3'd2,
    RG_MODE  = 3'd3,
    RG_NONE  = 3'd4
  } region_e;

  localparam logic [7:0] GATE_ON  = 8'h0A;
  localparam logic [7:0] GATE_OFF = 8'h00;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output region_e           region,
  output logic              hit
);
  logic [2:0] sel;

  always_comb begin
    sel = wr_addr[ADDR_W-1 -: 3];
    if (!wr_en || sel[2]) begin
      region = RG_NONE;
      hit    = 1'b0;
    end else begin
      region = region_e'({1'b0, sel[1:0]});
      hit    = 1'b1;
    end
  end
endmodule

// File: rtl/cbc_next.sv
module cbc_next
  import cbc_pkg::*;
#(
  parameter int ROM_BW = 7,
  parameter int RAM_BW = 2,
  parameter int LO_BW  = 5
) (
  input  region_e           region,
  input  logic              hit,
  input  logic [7:0]        data,
  input  logic [ROM_BW-1:0] cur_rom,
  input  logic              cur_mode,
  output logic [ROM_BW-1:0] rom_raw,
  output logic              rom_ld,
  output logic [RAM_BW-1:0] ram_nxt,
  output logic              ram_ld,
  output logic              gate_nxt,
  output logic              gate_ld,
  output logic              mode_nxt,
  output logic              mode_ld
);
  localparam int HI_BW = ROM_BW - LO_BW;

  logic [LO_BW-1:0] lo_val;

  always_comb begin
    lo_val   = data[LO_BW-1:0];
    rom_raw  = cur_rom;
    rom_ld   = 1'b0;
    ram_nxt  = '0;
    ram_ld   = 1'b0;
    gate_nxt = 1'b0;
    gate_ld  = 1'b0;
    mode_nxt = data[0];
    mode_ld  = 1'b0;
    if (hit) begin
      unique case (region)
        RG_GATE: begin
          if (data == GATE_ON) begin
            gate_nxt = 1'b1;
            gate_ld  = 1'b1;
          end else if (data == GATE_OFF) begin
            gate_nxt = 1'b0;
            gate_ld  = 1'b1;
          end
        end
        RG_LOW: begin
          if (lo_val == '0) lo_val = LO_BW'(1);
          rom_raw = {cur_rom[ROM_BW-1:LO_BW], lo_val};
          rom_ld  = 1'b1;
        end
        RG_SHARE: begin
          if (cur_mode) begin
            ram_nxt = data[RAM_BW-1:0];
            ram_ld  = 1'b1;
          end else begin
            rom_raw = {data[HI_BW-1:0], cur_rom[LO_BW-1:0]};
            rom_ld  = 1'b1;
          end
        end
        RG_MODE: begin
          mode_ld = 1'b1;
          if (data[0]) begin
            rom_raw = {{HI_BW{1'b0}}, cur_rom[LO_BW-1:0]};
            rom_ld  = 1'b1;
          end else begin
            ram_nxt = '0;
            ram_ld  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbc_wrap.sv
module cbc_wrap #(
  parameter int ROM_BW = 7
) (
  input  logic [ROM_BW:0]   size,
  input  logic [ROM_BW-1:0] raw,
  output logic [ROM_BW-1:0] wrapped
);
  logic [ROM_BW:0] mask_full;

  always_comb begin
    mask_full = size - 1'b1;
    wrapped   = raw & mask_full[ROM_BW-1:0];
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_BW = 7,
  parameter int RAM_BW = 2,
  parameter int LO_BW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ROM_BW:0]   rom_size,
  output logic [ROM_BW-1:0] rom_bank,
  output logic [RAM_BW-1:0] ram_bank,
  output logic              ram_en
);
  localparam logic [ROM_BW-1:0] ROM_RST = ROM_BW'(1);

  logic              rst_meta, rst_n_q;
  region_e           region;
  logic              hit;
  logic [ROM_BW-1:0] rom_q, rom_raw, rom_d;
  logic [RAM_BW-1:0] ram_q, ram_d;
  logic              gate_q, gate_d, mode_q, mode_d;
  logic              rom_ld, ram_ld, gate_ld, mode_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_q  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_q  <= rst_meta;
    end
  end

  cbc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .region (region),
    .hit    (hit)
  );

  cbc_next #(.ROM_BW(ROM_BW), .RAM_BW(RAM_BW), .LO_BW(LO_BW)) u_nxt (
    .region  (region),
    .hit     (hit),
    .data    (wr_data),
    .cur_rom (rom_q),
    .cur_mode(mode_q),
    .rom_raw (rom_raw),
    .rom_ld  (rom_ld),
    .ram_nxt (ram_d),
    .ram_ld  (ram_ld),
    .gate_nxt(gate_d),
    .gate_ld (gate_ld),
    .mode_nxt(mode_d),
    .mode_ld (mode_ld)
  );

  cbc_wrap #(.ROM_BW(ROM_BW)) u_wrap (
    .size   (rom_size),
    .raw    (rom_raw),
    .wrapped(rom_d)
  );

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      rom_q  <= ROM_RST;
      ram_q  <= '0;
      gate_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (rom_ld)  rom_q  <= rom_d;
      if (ram_ld)  ram_q  <= ram_d;
      if (gate_ld) gate_q <= gate_d;
      if (mode_ld) mode_q <= mode_d;
    end
  end

  assign rom_bank = rom_q;
  assign ram_bank = ram_q;
  assign ram_en   = gate_q;
endmodule

// File: rtl/cbc_chk.sv
module cbc_chk #(
  parameter int ADDR_W = 16,
  parameter int ROM_BW = 7,
  parameter int RAM_BW = 2
) (
  input logic              clk,
  input logic              rst_n_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [ROM_BW:0]   rom_size,
  input logic [ROM_BW-1:0] rom_bank,
  input logic [RAM_BW-1:0] ram_bank,
  input logic              ram_en,
  input logic              mode_q
);
  logic [ROM_BW:0] lim;
  logic            acc, in_gate, in_share, in_mode;

  always_comb begin
    lim      = rom_size - 1'b1;
    acc      = wr_en && !wr_addr[ADDR_W-1];
    in_gate  = acc && (wr_addr[ADDR_W-2:ADDR_W-3] == 2'd0);
    in_share = acc && (wr_addr[ADDR_W-2:ADDR_W-3] == 2'd2);
    in_mode  = acc && (wr_addr[ADDR_W-2:ADDR_W-3] == 2'd3);
  end

  // R8
  bank_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (rom_bank & ~lim[ROM_BW-1:0]) == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !acc |=> $stable({rom_bank, ram_bank, ram_en}));

  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !(in_gate && (wr_data == 8'h0A || wr_data == 8'h00)) |=> $stable(ram_en));

  // R3
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_gate && wr_data == 8'h0A) |=> ram_en);

  // R7
  mode0_ram_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_mode && !wr_data[0]) |=> (ram_bank == '0));

  // R6
  share_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_share && mode_q) |=> (ram_bank == $past(wr_data[RAM_BW-1:0])) && $stable(rom_bank));
endmodule

bind cart_bank_ctrl cbc_chk #(.ADDR_W(ADDR_W), .ROM_BW(ROM_BW), .RAM_BW(RAM_BW)) u_chk (
  .clk     (clk),
  .rst_n_q (rst_n_q),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rom_size(rom_size),
  .rom_bank(rom_bank),
  .ram_bank(ram_bank),
  .ram_en  (ram_en),
  .mode_q  (mode_q)
);

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rom_size;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [6:0] m_rom;
  logic [1:0] m_ram;
  logic       m_en, m_mode;

  always #5 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_size(rom_size), .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en)
  );

  function automatic logic [6:0] wrapb(logic [6:0] b, logic [7:0] sz);
    logic [7:0] m;
    m = sz - 8'd1;
    return b & m[6:0];
  endfunction

  function automatic string tag_of(logic [15:0] a, logic md);
    if (a[15]) return "R2";
    case (a[14:13])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return md ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [4:0] lo;
    if (a[15]) return;
    case (a[14:13])
      2'd0: begin
        if (d == 8'h0A) m_en = 1'b1;
        else if (d == 8'h00) m_en = 1'b0;
      end
      2'd1: begin
        lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
        m_rom = wrapb({m_rom[6:5], lo}, rom_size);
      end
      2'd2: begin
        if (m_mode) m_ram = d[1:0];
        else m_rom = wrapb({d[1:0], m_rom[4:0]}, rom_size);
      end
      default: begin
        m_mode = d[0];
        if (d[0]) m_rom = wrapb({2'b00, m_rom[4:0]}, rom_size);
        else m_ram = 2'd0;
      end
    endcase
  endtask

  task automatic check(string tag, logic [6:0] er, logic [1:0] ea, logic ee);
    n_cmp++;
    if (rom_bank !== er || ram_bank !== ea || ram_en !== ee) begin
      n_bad++;
      $display("FAIL %s: actual rom=%0h ram=%0d en=%0b expected rom=%0h ram=%0d en=%0b",
               tag, rom_bank, ram_bank, ram_en, er, ea, ee);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    string t;
    t = tag_of(a, m_mode);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    #2;
    check("R9", m_rom, m_ram, m_en);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check(t, m_rom, m_ram, m_en);
  endtask

  task automatic do_reset(logic [7:0] sz);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rom_size = sz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_rom = 7'd1; m_ram = 2'd0; m_en = 1'b0; m_mode = 1'b0;
    check("R1", 7'd1, 2'd0, 1'b0);
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          pick;
      a = 16'($urandom);
      if ($urandom % 8 != 0) a[15] = 1'b0;
      pick = $urandom % 10;
      d = (pick < 2) ? 8'h0A : (pick < 3) ? 8'h00 : 8'($urandom);
      if ($urandom % 6 == 0) begin
        @(negedge clk);
        #2 check("R2", m_rom, m_ram, m_en);
      end else begin
        wr(a, d);
      end
    end
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rom_size = 8'd128;
    do_reset(8'd128);

    wr(16'h2000, 8'h00);  check("R4 zero->1", 7'h01, 2'd0, 1'b0);
    wr(16'h3FFF, 8'hFF);  check("R4 low", 7'h1F, 2'd0, 1'b0);
    wr(16'h4000, 8'h03);  check("R5 upper", 7'h7F, 2'd0, 1'b0);
    wr(16'h2000, 8'h20);  check("R4 keep upper", 7'h61, 2'd0, 1'b0);
    wr(16'h6000, 8'h01);  check("R7 mode1 clear", 7'h01, 2'd0, 1'b0);
    wr(16'h5ABC, 8'hFE);  check("R6 ram bank", 7'h01, 2'd2, 1'b0);
    wr(16'h0000, 8'h0A);  check("R3 on", 7'h01, 2'd2, 1'b1);
    wr(16'h1FFF, 8'h05);  check("R3 other", 7'h01, 2'd2, 1'b1);
    wr(16'h8000, 8'h00);  check("R2 high addr", 7'h01, 2'd2, 1'b1);
    wr(16'hA000, 8'h01);  check("R2 high addr", 7'h01, 2'd2, 1'b1);
    wr(16'h6000, 8'h00);  check("R7 mode0 ram", 7'h01, 2'd0, 1'b1);
    wr(16'h0123, 8'h00);  check("R3 off", 7'h01, 2'd0, 1'b0);
    rand_run(3000);

    do_reset(8'd8);
    wr(16'h2000, 8'h1F);  check("R8 low wrap", 7'h07, 2'd0, 1'b0);
    wr(16'h4000, 8'h03);  check("R8 upper wrap", 7'h07, 2'd0, 1'b0);
    wr(16'h2000, 8'h08);  check("R8 wrap to 0", 7'h00, 2'd0, 1'b0);
    rand_run(2000);

    do_reset(8'd2);
    wr(16'h2000, 8'h02);  check("R8 two banks", 7'h00, 2'd0, 1'b0);
    rand_run(1500);

    do_reset(8'd32);
    rand_run(2000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule